// File: doc/BRIEF.md
# Ternary Route Lookup Table

A small ternary match table that resolves 32-bit destination keys to a next-hop code. Each slot holds a stored value, a care mask of the same width, a valid bit and a 4-bit next-hop result. A slot matches a key when every bit whose mask bit is one equals the stored bit. Bits whose mask bit is zero are not compared. All slots are compared in parallel. A fixed-priority encoder picks the matching slot with the lowest index, and that index selects the slot's next hop.

Software sets the routing policy by choosing where it writes each entry. It places longer prefixes at lower indices, so the most specific route wins. Entries are loaded through a single write port, and each write replaces one whole slot. A lookup is presented for one cycle. The registered answer appears on the following cycle with a response strobe, a hit flag, the next hop and the winning slot index.

Top module: `tcam_route_lookup`

## Requirements
- R1: After reset the response outputs are all zero and every slot is invalid, so a lookup issued before any write misses.
- R2: A slot compares a key bit only where its mask bit is 1. Where the mask bit is 0, that key bit is ignored, whatever the stored bit holds.
- R3: When several valid slots match, the response reports the matching slot with the lowest index and that slot's next hop.
- R4: With /24, /16 and /8 prefixes written at slots 0, 1 and 2, a key inside all three returns the /24 next hop. Keys inside only the /16 or only the /8 return those entries' next hops.
- R5: `rsp_valid` is high in exactly the cycle after a cycle with `lk_req` high, so back-to-back requests give back-to-back responses.
- R6: When no valid slot matches, the response has `rsp_hit`=0, `rsp_hop`=0 and `rsp_idx`=0.
- R7: A write is seen by lookups issued in later cycles. A lookup issued in the same cycle as a write sees the slot's previous contents.
- R8: A slot written with `wr_valid`=0 never matches, even when its value and mask would match the key.
- R9: While `rsp_valid` is low, `rsp_hit` and `rsp_hop` are 0.
- R10: A slot with an all-zero mask matches every key. Placed at the highest index (15), it acts as a default route that is used only when no other slot matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | 4 | Slot to write |
| wr_value | input | 32 | Stored comparison value |
| wr_mask | input | 32 | Care mask, 1 = compare bit |
| wr_valid | input | 1 | Valid bit stored in the slot |
| wr_hop | input | 4 | Next-hop result stored in the slot |
| lk_req | input | 1 | Lookup request this cycle |
| lk_key | input | 32 | Key to look up |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | At least one valid slot matched |
| rsp_hop | output | 4 | Next hop of the winning slot, 0 on miss |
| rsp_idx | output | 4 | Index of the winning slot, 0 on miss |

## Verification
Some properties are checked on every cycle. These are the one-cycle response timing, the zeroed outputs on a miss and while idle, and that a hit never names a slot whose valid bit was clear when the lookup was made; the checker tracks the valid bits from the write traffic to test this. Other behaviours are shown only by the bench's scenarios. These are the masked comparison, priority between overlapping slots, longest-prefix resolution, the default route, and the write/lookup ordering in the same cycle. Each of these needs a known table contents and a chosen key.

// File: rtl/tcam_route_lookup.sv
module tcam_route_lookup #(
  parameter int KEY_W   = 32,
  parameter int ENTRIES = 16,
  parameter int HOP_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic             wr_valid,
  input  logic [HOP_W-1:0] wr_hop,
  input  logic             lk_req,
  input  logic [KEY_W-1:0] lk_key,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [HOP_W-1:0] rsp_hop,
  output logic [IDX_W-1:0] rsp_idx
);

  logic [KEY_W-1:0] val_q  [ENTRIES];
  logic [KEY_W-1:0] mask_q [ENTRIES];
  logic [HOP_W-1:0] hop_q  [ENTRIES];
  logic [ENTRIES-1:0] live_q;
  logic [ENTRIES-1:0] match;
  logic             any_hit;
  logic [IDX_W-1:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        val_q[i]  <= '0;
        mask_q[i] <= '0;
        hop_q[i]  <= '0;
      end
    end else if (wr_en) begin
      live_q[wr_idx] <= wr_valid;
      val_q[wr_idx]  <= wr_value;
      mask_q[wr_idx] <= wr_mask;
      hop_q[wr_idx]  <= wr_hop;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_line
    assign match[g] = live_q[g] && (((lk_key ^ val_q[g]) & mask_q[g]) == '0);
  end

  always_comb begin
    any_hit = 1'b0;
    win     = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        any_hit = 1'b1;
        win     = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_hop   <= '0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && any_hit;
      rsp_hop   <= (lk_req && any_hit) ? hop_q[win] : '0;
      rsp_idx   <= (lk_req && any_hit) ? win : '0;
    end
  end

endmodule

module tcam_route_lookup_chk #(
  parameter int ENTRIES = 16,
  parameter int HOP_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_valid,
  input logic             lk_req,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [HOP_W-1:0] rsp_hop,
  input logic [IDX_W-1:0] rsp_idx
);

  logic [ENTRIES-1:0] seen_q;
  logic [ENTRIES-1:0] seen_lag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q   <= '0;
      seen_lag <= '0;
    end else begin
      seen_lag <= seen_q;
      if (wr_en) seen_q[wr_idx] <= wr_valid;
    end
  end

  AST_REQ_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n) lk_req |=> rsp_valid); // R5
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n) !lk_req |=> !rsp_valid); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_hit) |-> (rsp_hop == '0 && rsp_idx == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rsp_valid |-> (!rsp_hit && rsp_hop == '0)); // R9
  AST_HIT_LIVE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) rsp_hit |-> seen_lag[rsp_idx]); // R8

endmodule

bind tcam_route_lookup tcam_route_lookup_chk #(.ENTRIES(ENTRIES), .HOP_W(HOP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
  .lk_req(lk_req), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hop(rsp_hop), .rsp_idx(rsp_idx)
);

// File: tb/tcam_route_lookup_bench.sv
module tcam_route_lookup_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_value = '0;
  logic [31:0] wr_mask = '0;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_hop = '0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_key = '0;
  logic        rsp_valid, rsp_hit;
  logic [3:0]  rsp_hop, rsp_idx;

  int total = 0;
  int bad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  tcam_route_lookup u_tcam_route_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_value(wr_value),
    .wr_mask(wr_mask), .wr_valid(wr_valid), .wr_hop(wr_hop), .lk_req(lk_req),
    .lk_key(lk_key), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hop(rsp_hop),
    .rsp_idx(rsp_idx)
  );

  function automatic logic [31:0] pfx(int n);
    return (n == 0) ? 32'h0 : ~((32'h1 << (32 - n)) - 32'h1);
  endfunction

  task automatic drive(input logic we, input logic [3:0] idx, input logic [31:0] v,
                       input logic [31:0] m, input logic vl, input logic [3:0] hp,
                       input logic rq, input logic [31:0] key,
                       input logic eh, input logic [3:0] ehop, input logic [3:0] eidx,
                       input string tag);
    @(negedge clk);
    wr_en = we; wr_idx = idx; wr_value = v; wr_mask = m; wr_valid = vl; wr_hop = hp;
    lk_req = rq; lk_key = key;
    if (rq) begin
      exp_q.push_back({eh, ehop, eidx});
      tag_q.push_back(tag);
    end
  endtask

  task automatic put(input logic [3:0] idx, input logic [31:0] v, input int plen,
                     input logic vl, input logic [3:0] hp);
    drive(1'b1, idx, v, pfx(plen), vl, hp, 1'b0, '0, 1'b0, '0, '0, "");
  endtask

  task automatic look(input logic [31:0] key, input logic eh, input logic [3:0] ehop,
                      input logic [3:0] eidx, input string tag);
    drive(1'b0, '0, '0, '0, 1'b0, '0, 1'b1, key, eh, ehop, eidx, tag);
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, '0, 1'b0, '0, 1'b0, '0, 1'b0, '0, '0, "");
  endtask

  initial begin : monitor
    logic [8:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        if (rsp_valid) begin
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R5 unexpected response: got valid=1 expected valid=0");
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({rsp_hit, rsp_hop, rsp_idx} != e) begin
              bad++;
              $display("FAIL %s: got hit=%0b hop=%0d idx=%0d expected hit=%0b hop=%0d idx=%0d",
                       t, rsp_hit, rsp_hop, rsp_idx, e[8], e[7:4], e[3:0]);
            end
          end
        end else begin
          if (exp_q.size() != 0) begin
            total++; bad++;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            $display("FAIL R5 (%s) response missing: got valid=0 expected valid=1", t);
          end
          if (rsp_hit || rsp_hop != 0) begin
            total++; bad++;
            $display("FAIL R9 idle outputs: got hit=%0b hop=%0d expected 0 0", rsp_hit, rsp_hop);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: got running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    total++;
    if (rsp_valid || rsp_hit || rsp_hop != 0 || rsp_idx != 0) begin
      bad++;
      $display("FAIL R1 reset outputs: got %0b%0b %0d %0d expected all zero",
               rsp_valid, rsp_hit, rsp_hop, rsp_idx);
    end
    look(32'h0A01_0301, 1'b0, 4'd0, 4'd0, "R1 empty table miss");
    idle();

    put(4'd0, 32'h0A01_0300, 24, 1'b1, 4'd4);
    put(4'd1, 32'h0A01_0000, 16, 1'b1, 4'd2);
    put(4'd2, 32'h0A00_0000, 8,  1'b1, 4'd1);
    look(32'h0A01_0301, 1'b1, 4'd4, 4'd0, "R4 /24 wins");
    look(32'h0A01_0707, 1'b1, 4'd2, 4'd1, "R4 /16 only");
    look(32'h0A09_0909, 1'b1, 4'd1, 4'd2, "R4 /8 only");
    look(32'h0B00_0001, 1'b0, 4'd0, 4'd0, "R6 no match");
    idle();

    put(4'd3, 32'hC0A8_0001, 32, 1'b1, 4'd9);
    drive(1'b1, 4'd4, 32'hAB00_00FF, 32'hFF00_0000, 1'b1, 4'd5, 1'b0, '0, 1'b0, '0, '0, "");
    look(32'hC0A8_0001, 1'b1, 4'd9, 4'd3, "R2 exact match");
    look(32'hC0A8_0002, 1'b0, 4'd0, 4'd0, "R2 one cared bit differs");
    look(32'hAB12_3400, 1'b1, 4'd5, 4'd4, "R2 uncared bits ignored");
    idle();

    put(4'd9, 32'h0102_0304, 32, 1'b1, 4'd3);
    look(32'h0102_0304, 1'b1, 4'd3, 4'd9, "R3 single slot");
    put(4'd6, 32'h0102_0304, 32, 1'b1, 4'd6);
    look(32'h0102_0304, 1'b1, 4'd6, 4'd6, "R3 lower index wins");

    drive(1'b1, 4'd7, 32'h0505_0505, 32'hFFFF_FFFF, 1'b1, 4'd10,
          1'b1, 32'h0505_0505, 1'b0, 4'd0, 4'd0, "R7 same-cycle write not seen");
    look(32'h0505_0505, 1'b1, 4'd10, 4'd7, "R7 write seen next cycle");
    put(4'd7, 32'h0505_0505, 32, 1'b0, 4'd10);
    look(32'h0505_0505, 1'b0, 4'd0, 4'd0, "R8 invalidated slot");
    put(4'd8, 32'h0606_0606, 32, 1'b0, 4'd11);
    look(32'h0606_0606, 1'b0, 4'd0, 4'd0, "R8 slot written invalid");
    idle();

    put(4'd15, 32'h0, 0, 1'b1, 4'd15);
    look(32'h0B00_0001, 1'b1, 4'd15, 4'd15, "R10 default route");
    look(32'h0A01_0301, 1'b1, 4'd4, 4'd0, "R10 default loses to /24");
    look(32'hC0A8_0001, 1'b1, 4'd9, 4'd3, "R5 back-to-back");
    idle();
    idle();
    idle();

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5 pending responses: got %0d expected 0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule